// File: doc/BRIEF.md
# DDR4 Command and Address Pin Encoder

This block turns one abstract memory request per clock into the values of the DDR4 command and address pins for a single command cycle. A request names its kind (activate, read, write, precharge of one bank, precharge of all banks, or no-operation) and carries a bank group, bank, row, column, an auto-precharge flag and a chop-to-four flag. The block places each field on the pins that carry it for that kind of command. On an activate, the three upper row bits go onto the pins that otherwise act as RAS_n, CAS_n and WE_n. On reads, writes and precharges, address pins 10 and 12 act as command modifiers.

All pins come from flops on the rising clock edge, so each request shows up on the pins one cycle after it is presented. Cycles with no valid request drive a deselect, with chip select high. The block checks no command timing. It sits between a scheduler that has already made those decisions and the physical layer that drives the pins.

Top module: `cmd_addr_enc`

## Requirements
- R1: While the synchronous active-high reset is high at a rising edge, the next pin state has chip select high, the activate pin high, the three shared command pins high, and bank group, bank and all 14 address pins low.
- R2: Each request presented before a rising edge appears on the pins after that same edge, which is one cycle of latency. Back-to-back requests are encoded on consecutive cycles, with no gaps.
- R3: A cycle with the request-valid input low gives a deselect: chip select high, the activate pin high, command pins 111, and bank group, bank and address all zero.
- R4: An activate (kind code 1) gives chip select low and the activate pin low. Row bit 16 goes on the RAS_n/A16 pin, row bit 15 on CAS_n/A15, row bit 14 on WE_n/A14, and row bits 13..0 on A13..A0. The request's bank group and bank are driven.
- R5: A read (kind code 2) gives chip select low, the activate pin high, RAS_n/CAS_n/WE_n = 1,0,1, the column on A9..A0, and the request's bank group and bank.
- R6: A write (kind code 3) is encoded like a read, except that the command pins are 1,0,0.
- R7: On a read or write, A10 equals the auto-precharge flag (high means close the row when the access completes).
- R8: On a read or write, A11 and A13 are low. While the on-the-fly burst enable input is high, A12 is low when a chop to four is requested and high for a full burst of eight. While that enable is low, A12 is high whatever the chop flag says.
- R9: A single-bank precharge (kind code 4) gives chip select low, the activate pin high, command pins 0,1,0, A10 low, the other address pins low, and the request's bank group and bank.
- R10: A precharge of all banks (kind code 5) gives command pins 0,1,0, A10 high, the other address pins low, and bank group and bank driven to zero.
- R11: A no-operation (kind code 0) gives chip select low, the activate pin high, command pins 1,1,1, and bank group, bank and address all zero.
- R12: The unused kind codes 6 and 7 are encoded as a deselect, the same as R3. Request fields that a kind does not use have no effect on the pins: the row on reads, writes and precharges, the column and flags on activates, and the banks on precharge-all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 3 | Kind code: 0 nop, 1 activate, 2 read, 3 write, 4 precharge one, 5 precharge all |
| req_bg | input | BG_W (2) | Target bank group |
| req_ba | input | BA_W (2) | Target bank within the group |
| req_row | input | ROW_W (17) | Row address for an activate |
| req_col | input | COL_W (10) | Column address for a read or write |
| req_ap | input | 1 | Auto-precharge request on a read or write |
| req_bc4 | input | 1 | Chop-to-four request on a read or write |
| otf_bc_en | input | 1 | On-the-fly burst length selection enabled |
| cs_n | output | 1 | Chip select, active low |
| act_n | output | 1 | Activate pin, active low |
| ras_n_a16 | output | 1 | RAS_n command pin, or row bit 16 |
| cas_n_a15 | output | 1 | CAS_n command pin, or row bit 15 |
| we_n_a14 | output | 1 | WE_n command pin, or row bit 14 |
| bg | output | BG_W (2) | Bank group pins |
| ba | output | BA_W (2) | Bank pins |
| addr | output | A_W (14) | Address pins A13..A0 |

## Verification
Two functions can share one command cycle. The first case is an activate whose row has bits 14 to 16 set: the shared pins then show the same 1,1,1 pattern as a no-operation, and only the low activate pin separates the two. The second case is a read or write that asks for auto-precharge and a chop in the same cycle as an all-ones column. There the modifier pins A10 and A12 sit right next to the column field on the same bus. The sweep covers every combination of kind, valid, flags, burst enable and bank, with varied rows and columns. It adds walking-one rows on activates and walking-one columns with both modifiers set. Each resulting pin word is compared against a value the bench builds from the field positions in the requirements.

// File: rtl/ca_enc_pkg.sv
package ca_enc_pkg;

  typedef enum logic [2:0] {
    KIND_NOP  = 3'd0,
    KIND_ACT  = 3'd1,
    KIND_RD   = 3'd2,
    KIND_WR   = 3'd3,
    KIND_PRE  = 3'd4,
    KIND_PREA = 3'd5
  } ca_kind_e;

  // {RAS_n, CAS_n, WE_n} when the activate pin is high
  localparam logic [2:0] CMD_NOP = 3'b111;
  localparam logic [2:0] CMD_RD  = 3'b101;
  localparam logic [2:0] CMD_WR  = 3'b100;
  localparam logic [2:0] CMD_PRE = 3'b010;

  // address pins reused as command modifiers
  localparam int AP_POS = 10;
  localparam int BC_POS = 12;
  // number of pins that the shared command lines add above A_W
  localparam int SHARED_PINS = 3;

endpackage

// File: rtl/ca_act_enc.sv
module ca_act_enc #(
  parameter int A_W   = 14,
  parameter int ROW_W = 17
) (
  input  logic [ROW_W-1:0] row,
  output logic [2:0]       hi,   // [2]=A16/RAS_n, [1]=A15/CAS_n, [0]=A14/WE_n
  output logic [A_W-1:0]   a
);
  import ca_enc_pkg::*;

  assign a = row[A_W-1:0];

  for (genvar i = 0; i < SHARED_PINS; i++) begin : g_hi
    if (A_W + i < ROW_W) begin : g_used
      assign hi[i] = row[A_W+i];
    end else begin : g_zero
      assign hi[i] = 1'b0;
    end
  end

endmodule

// File: rtl/ca_cas_enc.sv
module ca_cas_enc #(
  parameter int A_W   = 14,
  parameter int COL_W = 10
) (
  input  logic             is_wr,
  input  logic [COL_W-1:0] col,
  input  logic             ap,
  input  logic             bc4,
  input  logic             otf_en,
  output logic [2:0]       cmd,
  output logic [A_W-1:0]   a
);
  import ca_enc_pkg::*;

  localparam int COL_LIM = (COL_W < AP_POS) ? COL_W : AP_POS;

  always_comb begin
    a = '0;
    for (int i = 0; i < COL_LIM; i++) a[i] = col[i];
    a[AP_POS] = ap;
    // low selects a chop of four; fixed high when burst length is not chosen per command
    a[BC_POS] = otf_en ? ~bc4 : 1'b1;
    cmd = is_wr ? CMD_WR : CMD_RD;
  end

endmodule

// File: rtl/ca_pre_enc.sv
module ca_pre_enc #(
  parameter int A_W = 14
) (
  input  logic           all_banks,
  output logic [2:0]     cmd,
  output logic [A_W-1:0] a,
  output logic           keep_bank
);
  import ca_enc_pkg::*;

  always_comb begin
    a         = '0;
    a[AP_POS] = all_banks;
    cmd       = CMD_PRE;
    keep_bank = ~all_banks;
  end

endmodule

// File: rtl/cmd_addr_enc.sv
module cmd_addr_enc #(
  parameter int BG_W  = 2,
  parameter int BA_W  = 2,
  parameter int ROW_W = 17,
  parameter int COL_W = 10,
  parameter int A_W   = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [2:0]       req_kind,
  input  logic [BG_W-1:0]  req_bg,
  input  logic [BA_W-1:0]  req_ba,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_ap,
  input  logic             req_bc4,
  input  logic             otf_bc_en,
  output logic             cs_n,
  output logic             act_n,
  output logic             ras_n_a16,
  output logic             cas_n_a15,
  output logic             we_n_a14,
  output logic [BG_W-1:0]  bg,
  output logic [BA_W-1:0]  ba,
  output logic [A_W-1:0]   addr
);
  import ca_enc_pkg::*;

  ca_kind_e kind;
  assign kind = ca_kind_e'(req_kind);

  // per-family encoders run in parallel; one mux picks the result
  logic [2:0]     act_hi;
  logic [A_W-1:0] act_a;
  logic [2:0]     cas_cmd;
  logic [A_W-1:0] cas_a;
  logic [2:0]     pre_cmd;
  logic [A_W-1:0] pre_a;
  logic           pre_keep;

  ca_act_enc #(.A_W(A_W), .ROW_W(ROW_W)) u_act (
    .row (req_row),
    .hi  (act_hi),
    .a   (act_a)
  );

  ca_cas_enc #(.A_W(A_W), .COL_W(COL_W)) u_cas (
    .is_wr  (kind == KIND_WR),
    .col    (req_col),
    .ap     (req_ap),
    .bc4    (req_bc4),
    .otf_en (otf_bc_en),
    .cmd    (cas_cmd),
    .a      (cas_a)
  );

  ca_pre_enc #(.A_W(A_W)) u_pre (
    .all_banks (kind == KIND_PREA),
    .cmd       (pre_cmd),
    .a         (pre_a),
    .keep_bank (pre_keep)
  );

  logic            nx_cs_n, nx_act_n;
  logic [2:0]      nx_cmd;
  logic [BG_W-1:0] nx_bg;
  logic [BA_W-1:0] nx_ba;
  logic [A_W-1:0]  nx_a;

  always_comb begin
    nx_cs_n  = 1'b1;
    nx_act_n = 1'b1;
    nx_cmd   = CMD_NOP;
    nx_bg    = '0;
    nx_ba    = '0;
    nx_a     = '0;
    if (req_valid) begin
      case (kind)
        KIND_NOP: begin
          nx_cs_n = 1'b0;
        end
        KIND_ACT: begin
          nx_cs_n  = 1'b0;
          nx_act_n = 1'b0;
          nx_cmd   = act_hi;
          nx_a     = act_a;
          nx_bg    = req_bg;
          nx_ba    = req_ba;
        end
        KIND_RD, KIND_WR: begin
          nx_cs_n = 1'b0;
          nx_cmd  = cas_cmd;
          nx_a    = cas_a;
          nx_bg   = req_bg;
          nx_ba   = req_ba;
        end
        KIND_PRE, KIND_PREA: begin
          nx_cs_n = 1'b0;
          nx_cmd  = pre_cmd;
          nx_a    = pre_a;
          nx_bg   = pre_keep ? req_bg : '0;
          nx_ba   = pre_keep ? req_ba : '0;
        end
        default: begin
          nx_cs_n = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n      <= 1'b1;
      act_n     <= 1'b1;
      ras_n_a16 <= 1'b1;
      cas_n_a15 <= 1'b1;
      we_n_a14  <= 1'b1;
      bg        <= '0;
      ba        <= '0;
      addr      <= '0;
    end else begin
      cs_n      <= nx_cs_n;
      act_n     <= nx_act_n;
      ras_n_a16 <= nx_cmd[2];
      cas_n_a15 <= nx_cmd[1];
      we_n_a14  <= nx_cmd[0];
      bg        <= nx_bg;
      ba        <= nx_ba;
      addr      <= nx_a;
    end
  end

endmodule

// File: rtl/cmd_addr_enc_chk.sv
module cmd_addr_enc_chk #(
  parameter int BG_W  = 2,
  parameter int BA_W  = 2,
  parameter int ROW_W = 17,
  parameter int COL_W = 10,
  parameter int A_W   = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [2:0]       req_kind,
  input logic [BG_W-1:0]  req_bg,
  input logic [BA_W-1:0]  req_ba,
  input logic [ROW_W-1:0] req_row,
  input logic [COL_W-1:0] req_col,
  input logic             req_ap,
  input logic             req_bc4,
  input logic             otf_bc_en,
  input logic             cs_n,
  input logic             act_n,
  input logic             ras_n_a16,
  input logic             cas_n_a15,
  input logic             we_n_a14,
  input logic [BG_W-1:0]  bg,
  input logic [BA_W-1:0]  ba,
  input logic [A_W-1:0]   addr
);

  logic is_cas;
  assign is_cas = req_valid && (req_kind == 3'd2 || req_kind == 3'd3);

  // R3
  a_r3_deselect: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (cs_n && act_n && ras_n_a16 && cas_n_a15 && we_n_a14 && addr == '0));

  // R4
  a_r4_activate_row: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 3'd1) |=>
      (!cs_n && !act_n && addr == $past(req_row[A_W-1:0])
       && bg == $past(req_bg) && ba == $past(req_ba)));

  // R4: the activate pin is never low without chip select
  a_r4_act_with_cs: assert property (@(posedge clk) disable iff (rst)
    !act_n |-> !cs_n);

  // R5
  a_r5_read_cmd: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 3'd2) |=>
      (!cs_n && act_n && {ras_n_a16, cas_n_a15, we_n_a14} == 3'b101
       && addr[COL_W-1:0] == $past(req_col)));

  // R7
  a_r7_auto_pre: assert property (@(posedge clk) disable iff (rst)
    is_cas |=> (addr[10] == $past(req_ap)));

  // R8
  a_r8_fixed_burst: assert property (@(posedge clk) disable iff (rst)
    (is_cas && !otf_bc_en) |=> addr[12]);

  // R10
  a_r10_pre_all: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 3'd5) |=>
      (addr[10] && bg == '0 && ba == '0 && {ras_n_a16, cas_n_a15, we_n_a14} == 3'b010));

endmodule

bind cmd_addr_enc cmd_addr_enc_chk #(
  .BG_W(BG_W), .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .A_W(A_W)
) u_chk (.*);

// File: tb/sim_cmd_addr_enc.sv
module sim_cmd_addr_enc;

  localparam int BG_W = 2, BA_W = 2, ROW_W = 17, COL_W = 10, A_W = 14;
  localparam int PW = 5 + BG_W + BA_W + A_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_kind = '0;
  logic [BG_W-1:0] req_bg = '0;
  logic [BA_W-1:0] req_ba = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_ap = 1'b0, req_bc4 = 1'b0, otf_bc_en = 1'b0;
  logic cs_n, act_n, ras_n_a16, cas_n_a15, we_n_a14;
  logic [BG_W-1:0] bg;
  logic [BA_W-1:0] ba;
  logic [A_W-1:0] addr;

  int vecs = 0;
  int errs = 0;

  always #4 clk = ~clk;

  cmd_addr_enc #(.BG_W(BG_W), .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .A_W(A_W)) u0 (.*);

  localparam logic [PW-1:0] IDLE_PINS = {5'b11111, {(PW-5){1'b0}}};

  function automatic logic [PW-1:0] model(
    input logic v, input logic [2:0] k, input logic [1:0] g, input logic [1:0] b,
    input logic [16:0] row, input logic [9:0] col, input logic ap, input logic bc, input logic otf);
    logic [13:0] a;
    if (!v || k > 3'd5) return IDLE_PINS;
    case (k)
      3'd0: return {5'b01111, 18'd0};
      3'd1: return {2'b00, row[16:14], g, b, row[13:0]};
      3'd2, 3'd3: begin
        a = {1'b0, (otf ? ~bc : 1'b1), 1'b0, ap, col};
        return {2'b01, (k == 3'd2) ? 3'b101 : 3'b100, g, b, a};
      end
      3'd4: return {2'b01, 3'b010, g, b, 14'd0};
      default: return {2'b01, 3'b010, 4'd0, 14'd1 << 10};
    endcase
  endfunction

  function automatic string tag_of(input logic v, input logic [2:0] k);
    if (!v) return "R3";
    case (k)
      3'd0: return "R11";
      3'd1: return "R4";
      3'd2: return "R5 R7 R8";
      3'd3: return "R6 R7 R8";
      3'd4: return "R9";
      3'd5: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input logic [PW-1:0] exp, input string tag);
    logic [PW-1:0] got;
    got = {cs_n, act_n, ras_n_a16, cas_n_a15, we_n_a14, bg, ba, addr};
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // R2: drive at a falling edge, sample at the next falling edge (one register)
  task automatic apply(input logic v, input logic [2:0] k, input logic [1:0] g, input logic [1:0] b,
                       input logic [16:0] row, input logic [9:0] col,
                       input logic ap, input logic bc, input logic otf, input string tag);
    req_valid = v; req_kind = k; req_bg = g; req_ba = b;
    req_row = row; req_col = col; req_ap = ap; req_bc4 = bc; otf_bc_en = otf;
    @(negedge clk);
    check(model(v, k, g, b, row, col, ap, bc, otf), tag);
  endtask

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check(IDLE_PINS, "R1");
    rst = 1'b0;

    // full sweep of kind, valid, flags, burst enable and banks (R2..R12)
    for (int i = 0; i < 2048; i++) begin
      logic [16:0] row;
      logic [9:0] col;
      row = 17'(i * 32'h1F3D5 + 32'h0ABC);
      col = 10'(i * 37) ^ 10'h2AA;
      apply(i[3], i[2:0], i[8:7], i[10:9], row, col, i[4], i[5], i[6], tag_of(i[3], i[2:0]));
    end

    // R4: walking-one rows, plus upper bits all set (looks like 1,1,1 on command pins)
    for (int j = 0; j < 17; j++)
      apply(1'b1, 3'd1, 2'(j), 2'(j + 1), 17'd1 << j, 10'h3FF, 1'b1, 1'b1, 1'b1, "R4");
    apply(1'b1, 3'd1, 2'd3, 2'd3, 17'h1C000, 10'd0, 1'b0, 1'b0, 1'b0, "R4");
    apply(1'b1, 3'd1, 2'd0, 2'd0, 17'h1FFFF, 10'd0, 1'b0, 1'b0, 1'b0, "R4");

    // R7 R8: walking-one columns with auto-precharge and chop together, then all-ones column
    for (int j = 0; j < 10; j++) begin
      apply(1'b1, 3'd2, 2'd1, 2'd2, 17'h1FFFF, 10'd1 << j, 1'b1, 1'b1, 1'b1, "R7 R8");
      apply(1'b1, 3'd3, 2'd2, 2'd1, 17'h1FFFF, 10'd1 << j, 1'b0, 1'b0, 1'b1, "R7 R8");
    end
    apply(1'b1, 3'd2, 2'd3, 2'd3, 17'h1FFFF, 10'h3FF, 1'b1, 1'b1, 1'b1, "R7 R8");
    apply(1'b1, 3'd3, 2'd3, 2'd3, 17'h1FFFF, 10'h3FF, 1'b1, 1'b1, 1'b0, "R8");

    // R1: reset in the middle of traffic overrides a valid activate
    req_valid = 1'b1; req_kind = 3'd1; req_row = 17'h0F0F0; req_bg = 2'd2; req_ba = 2'd1;
    rst = 1'b1;
    @(negedge clk);
    check(IDLE_PINS, "R1");
    rst = 1'b0;
    apply(1'b1, 3'd5, 2'd3, 2'd3, 17'h0, 10'h0, 1'b0, 1'b0, 1'b0, "R10");
    apply(1'b0, 3'd1, 2'd3, 2'd3, 17'h1FFFF, 10'h3FF, 1'b1, 1'b1, 1'b1, "R3");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule